// File: doc/BRIEF.md
# Counter-Line Coalescing Write Queue

This block is a write queue for an encrypted persistent memory controller. Once an entry is accepted, it counts as durable. The queue holds two kinds of entries: data-line writes and counter-line writes. A single counter line holds the counters for every line of one page. Because of this, each write to a page produces a new full version of the same counter line, and any older pending version of it is now stale.

When a counter entry is accepted and an older counter entry for the same page is still waiting in the queue, the older one is removed. The new one is appended at the tail. Memory therefore receives only the latest counter version, and that version always drains after the data entry that was pushed before it. Data entries are never merged. The head entry is the one currently offered to memory, so it counts as started and is never removed.

A writer pushes entries through a valid/ready enqueue port. Memory pulls them from a valid/ready drain port, in queue order.

Top module: `ctr_coalesce_wq`

## Requirements
- R1: After reset the queue is empty: `drn_valid_o` is low and `enq_ready_o` is high.
- R2: `enq_kind_i` = 0 marks a data entry and 1 marks a counter entry. When nothing is coalesced, entries drain in acceptance order with their kind, address and payload unchanged.
- R3: Data entries are never merged. Two data entries to the same address both drain.
- R4: An accepted counter entry removes an older pending counter entry of the same page. The new entry takes the tail position, and the other entries keep their relative order.
- R5: Two counter entries are of the same page when address bits `[ADDR_W-1:log2(LINES_PER_PAGE)]` are equal; the low line-offset bits are ignored. Counter entries for different pages are all kept.
- R6: The head entry (the one shown on the drain port) never takes part in coalescing.
- R7: While `drn_valid_o` is high and `drn_ready_i` is low, the drain outputs stay valid and unchanged on the next cycle.
- R8: With DEPTH entries held, `enq_ready_o` is low and an offered entry is not accepted.
- R9: A push and a drain in the same cycle (with or without coalescing) are both carried out.
- R10: Writes A, Ac, B, Bc, C, Cc, D, Dc to four lines of one page, pushed while the drain is stalled, drain as exactly A, B, C, D, Dc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | An entry is offered |
| enq_kind_i | input | 1 | 0 = data entry, 1 = counter entry |
| enq_addr_i | input | ADDR_W | Line address of the entry |
| enq_data_i | input | DATA_W | Line payload |
| enq_ready_o | output | 1 | A free slot is available |
| drn_valid_o | output | 1 | The head entry is offered to memory |
| drn_kind_o | output | 1 | Kind of the head entry |
| drn_addr_o | output | ADDR_W | Address of the head entry |
| drn_data_o | output | DATA_W | Payload of the head entry |
| drn_ready_i | input | 1 | Memory accepts the head entry |

## Verification
Some rules are checked by assertions on every cycle:
- the occupancy stays bounded and steps exactly by pushes, drains and removals;
- a removal happens only when a counter entry is accepted;
- a stalled head holds steady;
- an empty queue shows idle outputs.

Other behaviours can only be shown by the bench scenarios:
- which entry is removed, and that the new one lands behind its data;
- that matching uses only the page bits;
- that the head is spared;
- that data to the same address is never merged.

The bench shows these by comparing every drained entry against a behavioural queue model.

// File: rtl/ctr_coalesce_pkg.sv
package ctr_coalesce_pkg;
  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_CTR  = 1'b1
  } kind_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cwq_match.sv
module cwq_match #(
  parameter int DEPTH  = 8,
  parameter int PAGE_W = 20,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic                          req_ctr_i,
  input  logic [PAGE_W-1:0]             req_page_i,
  input  logic [DEPTH-1:0]              slot_ctr_i,
  input  logic [DEPTH-1:0][PAGE_W-1:0]  slot_page_i,
  input  logic [CNT_W-1:0]              count_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              hit_idx_o
);
  logic [DEPTH-1:0] cand;

  // slot 0 is the head: already started, never a candidate
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cand[i] = (i != 0) && req_ctr_i && slot_ctr_i[i] &&
                (CNT_W'(i) < count_i) && (slot_page_i[i] == req_page_i);
    end
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cwq_store.sv
module cwq_store #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 512,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic                          pop_i,
  input  logic                          kill_i,
  input  logic [IDX_W-1:0]              kill_idx_i,
  input  logic                          new_ctr_i,
  input  logic [ADDR_W-1:0]             new_addr_i,
  input  logic [DATA_W-1:0]             new_data_i,
  output logic [CNT_W-1:0]              count_o,
  output logic [DEPTH-1:0]              slot_ctr_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr_o,
  output logic [DEPTH-1:0][DATA_W-1:0]  slot_data_o
);
  logic [CNT_W-1:0]             count_q, count_d;
  logic [DEPTH-1:0]             ctr_q, ctr_d;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [DEPTH-1:0][DATA_W-1:0] data_q, data_d;

  // compacting shift: drop head on pop, drop killed slot, append at the new tail
  always_comb begin
    int keep;
    keep    = int'(count_q) - int'(pop_i) - int'(kill_i);
    count_d = CNT_W'(keep + int'(push_i));
    for (int i = 0; i < DEPTH; i++) begin
      int s;
      s = i + int'(pop_i);
      if (kill_i && int'(kill_idx_i) <= s) s = s + 1;
      if (i < keep && s < DEPTH) begin
        ctr_d[i]  = ctr_q[s];
        addr_d[i] = addr_q[s];
        data_d[i] = data_q[s];
      end else if (push_i && i == keep) begin
        ctr_d[i]  = new_ctr_i;
        addr_d[i] = new_addr_i;
        data_d[i] = new_data_i;
      end else begin
        ctr_d[i]  = ctr_q[i];
        addr_d[i] = addr_q[i];
        data_d[i] = data_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      ctr_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      count_q <= count_d;
      ctr_q   <= ctr_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign count_o     = count_q;
  assign slot_ctr_o  = ctr_q;
  assign slot_addr_o = addr_q;
  assign slot_data_o = data_q;
endmodule

// File: rtl/ctr_coalesce_wq.sv
module ctr_coalesce_wq
  import ctr_coalesce_pkg::*;
#(
  parameter int DEPTH          = 8,
  parameter int ADDR_W         = 26,
  parameter int DATA_W         = 512,
  parameter int LINES_PER_PAGE = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_valid_i,
  input  logic              enq_kind_i,
  input  logic [ADDR_W-1:0] enq_addr_i,
  input  logic [DATA_W-1:0] enq_data_i,
  output logic              enq_ready_o,
  output logic              drn_valid_o,
  output logic              drn_kind_o,
  output logic [ADDR_W-1:0] drn_addr_o,
  output logic [DATA_W-1:0] drn_data_o,
  input  logic              drn_ready_i
);
  localparam int OFF_W  = $clog2(LINES_PER_PAGE);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int IDX_W  = idx_width(DEPTH);

  logic [CNT_W-1:0]             count_q;
  logic [DEPTH-1:0]             slot_ctr;
  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;
  logic [DEPTH-1:0][PAGE_W-1:0] slot_page;
  logic                         push, pop, kill, hit;
  logic [IDX_W-1:0]             hit_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_page
    assign slot_page[g] = slot_addr[g][ADDR_W-1:OFF_W];
  end

  assign enq_ready_o = (count_q < CNT_W'(DEPTH));
  assign drn_valid_o = (count_q != '0);
  assign push        = enq_valid_i && enq_ready_o;
  assign pop         = drn_valid_o && drn_ready_i;
  assign kill        = push && hit;

  cwq_match #(
    .DEPTH(DEPTH), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_match (
    .req_ctr_i  (kind_e'(enq_kind_i) == KIND_CTR),
    .req_page_i (enq_addr_i[ADDR_W-1:OFF_W]),
    .slot_ctr_i (slot_ctr),
    .slot_page_i(slot_page),
    .count_i    (count_q),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx)
  );

  cwq_store #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .kill_i     (kill),
    .kill_idx_i (hit_idx),
    .new_ctr_i  (enq_kind_i),
    .new_addr_i (enq_addr_i),
    .new_data_i (enq_data_i),
    .count_o    (count_q),
    .slot_ctr_o (slot_ctr),
    .slot_addr_o(slot_addr),
    .slot_data_o(slot_data)
  );

  assign drn_kind_o = slot_ctr[0];
  assign drn_addr_o = slot_addr[0];
  assign drn_data_o = slot_data[0];
endmodule

// File: rtl/ctr_coalesce_wq_chk.sv
module ctr_coalesce_wq_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 512,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  count_q,
  input logic              push,
  input logic              pop,
  input logic              kill,
  input logic              enq_kind_i,
  input logic              enq_ready_o,
  input logic              drn_valid_o,
  input logic              drn_kind_o,
  input logic [ADDR_W-1:0] drn_addr_o,
  input logic [DATA_W-1:0] drn_data_o,
  input logic              drn_ready_i
);
  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= DEPTH);

  // R8
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(count_q) == DEPTH && !drn_ready_i) |=> int'(count_q) == DEPTH);

  // R1
  empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) |-> (!drn_valid_o && enq_ready_o));

  // R7
  drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drn_valid_o && !drn_ready_i) |=>
      (drn_valid_o && $stable(drn_kind_o) && $stable(drn_addr_o) && $stable(drn_data_o)));

  // R4
  kill_on_ctr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |-> (push && enq_kind_i));

  // R9
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push || pop) |=> int'(count_q) ==
      int'($past(count_q)) + int'($past(push)) - int'($past(pop)) - int'($past(kill)));
endmodule

bind ctr_coalesce_wq ctr_coalesce_wq_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .count_q    (count_q),
  .push       (push),
  .pop        (pop),
  .kill       (kill),
  .enq_kind_i (enq_kind_i),
  .enq_ready_o(enq_ready_o),
  .drn_valid_o(drn_valid_o),
  .drn_kind_o (drn_kind_o),
  .drn_addr_o (drn_addr_o),
  .drn_data_o (drn_data_o),
  .drn_ready_i(drn_ready_i)
);

// File: tb/ctr_coalesce_wq_test.sv
`timescale 1ns/1ps
module ctr_coalesce_wq_test;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int DW    = 64;
  localparam int LPP   = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          enq_valid_i = 1'b0;
  logic          enq_kind_i = 1'b0;
  logic [AW-1:0] enq_addr_i = '0;
  logic [DW-1:0] enq_data_i = '0;
  logic          enq_ready_o;
  logic          drn_valid_o;
  logic          drn_kind_o;
  logic [AW-1:0] drn_addr_o;
  logic [DW-1:0] drn_data_o;
  logic          drn_ready_i = 1'b0;

  always #4 clk = ~clk;

  ctr_coalesce_wq #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .LINES_PER_PAGE(LPP)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid_i), .enq_kind_i(enq_kind_i), .enq_addr_i(enq_addr_i),
    .enq_data_i(enq_data_i), .enq_ready_o(enq_ready_o),
    .drn_valid_o(drn_valid_o), .drn_kind_o(drn_kind_o), .drn_addr_o(drn_addr_o),
    .drn_data_o(drn_data_o), .drn_ready_i(drn_ready_i)
  );

  typedef struct {
    bit            k;
    int            a;
    logic [DW-1:0] d;
  } ent_t;

  ent_t  mq[$];
  int    n_run = 0;
  int    n_fail = 0;
  int    pops_seen = 0;
  string tag = "R1";
  bit    done = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(drn_valid_o === (mq.size() > 0), "drn_valid_o", longint'(drn_valid_o), longint'(mq.size() > 0));
    chk(enq_ready_o === (mq.size() < DEPTH), "enq_ready_o", longint'(enq_ready_o), longint'(mq.size() < DEPTH));
    if (mq.size() > 0) begin
      chk(drn_kind_o === mq[0].k, "drn_kind_o", longint'(drn_kind_o), longint'(mq[0].k));
      chk(drn_addr_o === AW'(mq[0].a), "drn_addr_o", longint'(drn_addr_o), longint'(mq[0].a));
      chk(drn_data_o === mq[0].d, "drn_data_o", longint'(drn_data_o), longint'(mq[0].d));
    end
  endtask

  // one cycle: check outputs, drive inputs, advance the model to the next edge
  task automatic step(input bit v, input bit k, input int a, input logic [DW-1:0] d, input bit r);
    bit pop, push;
    int kidx;
    @(negedge clk);
    compare();
    enq_valid_i = v;
    enq_kind_i  = k;
    enq_addr_i  = AW'(a);
    enq_data_i  = d;
    drn_ready_i = r;
    if (r && drn_valid_o) pops_seen++;
    pop  = r && (mq.size() > 0);
    push = v && (mq.size() < DEPTH);
    kidx = -1;
    if (push && k) begin
      for (int i = 1; i < mq.size(); i++) begin
        if (kidx < 0 && mq[i].k && (mq[i].a / LPP) == (a / LPP)) kidx = i;
      end
    end
    if (kidx > 0) mq.delete(kidx);
    if (pop) mq.delete(0);
    if (push) mq.push_back('{k: k, a: a, d: d});
  endtask

  task automatic push_st(input bit k, input int a);
    step(1'b1, k, a, {$urandom, $urandom}, 1'b0);
  endtask

  task automatic drain_all();
    for (int n = 0; n < 4 * DEPTH && mq.size() > 0; n++) step(1'b0, 1'b0, 0, '0, 1'b1);
    step(1'b0, 1'b0, 0, '0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    tag = "R1";
    repeat (2) step(1'b0, 1'b0, 0, '0, 1'b0);

    tag = "R2";
    push_st(1'b0, 10); push_st(1'b1, 200); push_st(1'b0, 11); push_st(1'b1, 300);
    drain_all();

    tag = "R10";
    pops_seen = 0;
    for (int i = 0; i < 4; i++) begin
      push_st(1'b0, 3 * LPP + i);
      push_st(1'b1, 3 * LPP);
    end
    tag = "R7";
    repeat (3) step(1'b0, 1'b0, 0, '0, 1'b0);
    tag = "R10";
    drain_all();
    chk(pops_seen == 5, "drained entries A,B,C,D,Dc", pops_seen, 5);

    tag = "R5";
    pops_seen = 0;
    push_st(1'b0, 5 * LPP + 1);
    push_st(1'b1, 5 * LPP + 7);
    push_st(1'b1, 6 * LPP + 7);
    push_st(1'b1, 5 * LPP + 60);
    drain_all();
    chk(pops_seen == 3, "page-only match", pops_seen, 3);

    tag = "R3";
    pops_seen = 0;
    push_st(1'b0, 77); push_st(1'b0, 77); push_st(1'b0, 77);
    drain_all();
    chk(pops_seen == 3, "data never merged", pops_seen, 3);

    tag = "R6";
    pops_seen = 0;
    push_st(1'b1, 9 * LPP);
    push_st(1'b1, 9 * LPP + 2);
    drain_all();
    chk(pops_seen == 2, "head spared", pops_seen, 2);

    tag = "R8";
    for (int i = 0; i < DEPTH; i++) push_st(1'b0, 100 + i);
    push_st(1'b0, 999);
    push_st(1'b1, 999);
    drain_all();

    tag = "R9";
    for (int n = 0; n < 3000; n++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           int'($urandom_range(0, 4 * LPP - 1)), {$urandom, $urandom},
           $urandom_range(0, 2) != 0);
    tag = "R4";
    push_st(1'b0, 2 * LPP + 4); push_st(1'b1, 2 * LPP); push_st(1'b0, 2 * LPP + 5);
    step(1'b1, 1'b1, 2 * LPP, {$urandom, $urandom}, 1'b1);
    drain_all();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule